// File: doc/BRIEF.md
# Shift-Add Signed Coefficient Multiplier

This block scales an unsigned pixel by a small signed coefficient without using a general multiplier. The coefficient comes from two user parameters, a sharpening weight S and a clamp weight C. A mode input picks the coefficient: either the difference S−C or the difference S−C−1. Both are needed when a sharpening pre-filter and a clamping pre-filter are folded into one kernel. The coefficient magnitude is split into three multiplexer choices. One picks nothing or the pixel. One picks nothing or four times the pixel. One picks nothing, eight times or sixteen times the pixel. The three choices are added, and a sign stage attaches the coefficient's sign, so the result is in sign-magnitude form. A magnitude that the three choices cannot form raises an error flag, and the product is then forced to zero.

Operands enter through a valid/ready stream. An operand is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Results leave through a second valid/ready stream held in one output register. While `out_valid` is high and `out_ready` is low, the result is frozen. `in_ready` is low in that state, so new operands are held off. `in_ready` is high whenever the register is empty or is being drained in the same cycle. This gives full throughput with no bubble when the consumer is always ready.

Top module: `shiftadd_coef_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_sub_one` = 0, the coefficient is S−C, and `out_mag` equals |S−C| times the pixel.
- R3: With `in_sub_one` = 1, the coefficient is S−C−1, and `out_mag` equals |S−C−1| times the pixel.
- R4: `out_neg` is 1 exactly when the selected difference is below zero and supported. This holds even when the pixel is 0, so the result can be a negative zero.
- R5: The supported magnitudes are 0 to 21 with the bit of value 2 clear: {0,1,4,5,8,9,12,13,16,17,20,21}. For any other magnitude, `out_err` is 1, `out_mag` is 0 and `out_neg` is 0.
- R6: Suppose an operand is accepted on an edge while the output register is empty or being drained. Its result is present with `out_valid` = 1 right after that edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. The result fields also stay unchanged until they are taken.
- R8: Results come out in the order their operands were accepted. Every accepted operand yields exactly one result.
- R9: The largest product, 21 × 255 = 5355, is exact in the 14-bit magnitude, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_pixel | input | 8 | Unsigned pixel value |
| in_s | input | 5 | Sharpening weight S, unsigned |
| in_c | input | 5 | Clamp weight C, unsigned |
| in_sub_one | input | 1 | 0: coefficient S−C; 1: coefficient S−C−1 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_neg | output | 1 | Sign of the result, 1 is negative |
| out_mag | output | 14 | Magnitude of the product |
| out_err | output | 1 | Coefficient magnitude not formable |

## Verification
The S and C pairs are chosen so that each multiplexer position is tried with each of its choices. Both modes are used, so that an S−C decode cannot pass for an S−C−1 decode. Negative differences are included, one of them with a zero pixel, to show that the sign comes from the difference and not from the product.

The unsupported magnitudes 2, 3, 6, 22 and 30 are used to separate the error path from wrapping or truncation. The pair S = 22 with the S−C−1 mode lands exactly on the supported edge value 21. A sweep under periodic back-pressure, plus one fully stalled result, shows that results are held, kept in order and never lost.

// File: rtl/coef_pkg.sv
package coef_pkg;

  // choice of the high multiplexer (bit pattern equals magnitude bits [4:3])
  typedef enum logic [1:0] {
    HI_NONE = 2'b00,
    HI_X8   = 2'b01,
    HI_X16  = 2'b10
  } hi_sel_e;

  typedef struct packed {
    logic    pick1;
    logic    pick4;
    hi_sel_e hi;
  } tap_sel_t;

  localparam int MAX_COEF = 21;
  localparam int TAP_SHIFTS = 5;

endpackage

// File: rtl/coef_decode.sv
module coef_decode
  import coef_pkg::*;
#(
  parameter int PAR_W = 5
) (
  input  logic [PAR_W-1:0] s_val,
  input  logic [PAR_W-1:0] c_val,
  input  logic             sub_one,
  output tap_sel_t         sel,
  output logic             neg,
  output logic             unsup
);

  localparam int DW = PAR_W + 2;

  logic signed [DW-1:0] diff;
  logic        [DW-1:0] abs_v;
  logic                 upper_zero;
  logic                 ok;

  always_comb begin
    diff  = $signed({2'b00, s_val}) - $signed({2'b00, c_val})
          - $signed({{(DW-1){1'b0}}, sub_one});
    abs_v = diff[DW-1] ? DW'(-diff) : DW'(diff);
    upper_zero = (abs_v >> 5) == '0;
    ok = upper_zero && !abs_v[1] && (abs_v[4:3] != 2'b11);

    sel.pick1 = ok & abs_v[0];
    sel.pick4 = ok & abs_v[2];
    sel.hi    = HI_NONE;
    if (ok) begin
      case (abs_v[4:3])
        2'b01:   sel.hi = HI_X8;
        2'b10:   sel.hi = HI_X16;
        default: sel.hi = HI_NONE;
      endcase
    end
    neg   = ok & diff[DW-1];
    unsup = !ok;
  end

endmodule

// File: rtl/shift_add_core.sv
module shift_add_core
  import coef_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAG_W = PIX_W + 6
) (
  input  logic [PIX_W-1:0] pixel,
  input  tap_sel_t         sel,
  output logic [MAG_W-1:0] mag
);

  logic [MAG_W-1:0] shifted [TAP_SHIFTS];
  logic [MAG_W-1:0] term_lo, term_mid, term_hi;

  for (genvar k = 0; k < TAP_SHIFTS; k++) begin : g_shift
    assign shifted[k] = {{(MAG_W-PIX_W){1'b0}}, pixel} << k;
  end

  always_comb begin
    term_lo  = sel.pick1 ? shifted[0] : '0;
    term_mid = sel.pick4 ? shifted[2] : '0;
    case (sel.hi)
      HI_X8:   term_hi = shifted[3];
      HI_X16:  term_hi = shifted[4];
      default: term_hi = '0;
    endcase
    mag = term_lo + term_mid + term_hi;
  end

  // shifted[1] is the x2 tap, kept for the structure but not chosen by any mux
  logic unused_x2;
  assign unused_x2 = ^shifted[1];

  always_comb begin
    AST_MAG_BOUND: assert (mag <= ({{(MAG_W-PIX_W){1'b0}}, pixel} * MAG_W'(MAX_COEF)))
      else $error("magnitude above largest coefficient times pixel"); // R9
  end

endmodule

// File: rtl/sign_stage.sv
module sign_stage #(
  parameter int MAG_W = 14
) (
  input  logic [MAG_W-1:0] mag_in,
  input  logic             neg_in,
  input  logic             unsup_in,
  output logic [MAG_W-1:0] mag_out,
  output logic             neg_out,
  output logic             err_out
);

  always_comb begin
    mag_out = unsup_in ? '0 : mag_in;
    neg_out = unsup_in ? 1'b0 : neg_in;
    err_out = unsup_in;
  end

endmodule

// File: rtl/shiftadd_coef_unit.sv
module shiftadd_coef_unit
  import coef_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int PAR_W = 5,
  localparam int MAG_W = PIX_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic [PAR_W-1:0] in_s,
  input  logic [PAR_W-1:0] in_c,
  input  logic             in_sub_one,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_neg,
  output logic [MAG_W-1:0] out_mag,
  output logic             out_err
);

  tap_sel_t         sel;
  logic             dec_neg, dec_unsup;
  logic [MAG_W-1:0] raw_mag, nxt_mag;
  logic             nxt_neg, nxt_err;

  coef_decode #(.PAR_W(PAR_W)) u_decode (
    .s_val   (in_s),
    .c_val   (in_c),
    .sub_one (in_sub_one),
    .sel     (sel),
    .neg     (dec_neg),
    .unsup   (dec_unsup)
  );

  shift_add_core #(.PIX_W(PIX_W), .MAG_W(MAG_W)) u_core (
    .pixel (in_pixel),
    .sel   (sel),
    .mag   (raw_mag)
  );

  sign_stage #(.MAG_W(MAG_W)) u_sign (
    .mag_in   (raw_mag),
    .neg_in   (dec_neg),
    .unsup_in (dec_unsup),
    .mag_out  (nxt_mag),
    .neg_out  (nxt_neg),
    .err_out  (nxt_err)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_neg   <= 1'b0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mag <= nxt_mag;
        out_neg <= nxt_neg;
        out_err <= nxt_err;
      end
    end
  end

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> (out_mag == '0) && !out_neg); // R5

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mag)
                                && $stable(out_neg) && $stable(out_err)); // R7

endmodule

// File: tb/shiftadd_coef_unit_tb.sv
module shiftadd_coef_unit_tb;

  localparam int PIX_W = 8;
  localparam int PAR_W = 5;
  localparam int MAG_W = PIX_W + 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PIX_W-1:0] in_pixel = '0;
  logic [PAR_W-1:0] in_s = '0;
  logic [PAR_W-1:0] in_c = '0;
  logic             in_sub_one = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic             out_neg;
  logic [MAG_W-1:0] out_mag;
  logic             out_err;

  int n_checks = 0;
  int n_fail   = 0;
  int bp_mode  = 0;   // 0 always ready, 1 periodic stall, 2 never ready
  int cyc      = 0;
  bit done     = 0;

  logic [MAG_W+1:0] exp_q [$];
  string            tag_q [$];

  always #2.5 clk = ~clk;

  shiftadd_coef_unit #(.PIX_W(PIX_W), .PAR_W(PAR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_s(in_s), .in_c(in_c), .in_sub_one(in_sub_one),
    .out_valid(out_valid), .out_ready(out_ready), .out_neg(out_neg),
    .out_mag(out_mag), .out_err(out_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [MAG_W+1:0] model(input int pix, input int s, input int c, input int m);
    int d, a;
    bit err;
    d = s - c - m;
    a = (d < 0) ? -d : d;
    err = !((a <= 21) && ((a % 4) < 2));
    if (err) return {1'b1, 1'b0, MAG_W'(0)};
    return {1'b0, (d < 0), MAG_W'(a * pix)};
  endfunction

  task automatic send(input int pix, input int s, input int c, input int m, input string tag);
    @(negedge clk); #2;
    in_valid = 1'b1; in_pixel = PIX_W'(pix); in_s = PAR_W'(s); in_c = PAR_W'(c);
    in_sub_one = m[0];
    while (!in_ready) begin @(negedge clk); #2; end
    exp_q.push_back(model(pix, s, c, m));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk); #2;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    logic [MAG_W+1:0] e;
    string t;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected result", int'(out_mag), -1);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_err, out_neg, out_mag} == e, t,
                int'({out_err, out_neg, out_mag}), int'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [MAG_W-1:0] held;
    repeat (3) @(negedge clk);
    #3;
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R6: single operand, result right after the accepting edge
    send(10, 12, 3, 0, "R2 coef 9 x10");
    idle(); #1;
    check(out_valid == 1'b1, "R6 latency one edge", int'(out_valid), 1);

    // R2 mode S-C
    send(100, 10, 5, 0, "R2 coef 5 x100");
    send(77, 9, 0, 0, "R2 coef 9 x77");
    send(200, 16, 0, 0, "R2 coef 16 x200");
    send(255, 21, 0, 0, "R9 coef 21 x255");
    // R3 mode S-C-1
    send(200, 10, 5, 1, "R3 coef 4 x200");
    send(33, 14, 1, 1, "R3 coef 12 x33");
    send(255, 22, 0, 1, "R3 edge coef 21 x255");
    // R4 sign
    send(50, 3, 8, 0, "R4 coef -5 x50");
    send(0, 7, 7, 1, "R4 coef -1 x0 negative zero");
    send(255, 0, 21, 0, "R4 coef -21 x255");
    send(9, 4, 12, 1, "R4 coef -9 x9");
    // R5 unsupported
    send(99, 7, 5, 0, "R5 mag 2");
    send(99, 7, 4, 0, "R5 mag 3");
    send(99, 6, 0, 0, "R5 mag 6");
    send(99, 0, 22, 0, "R5 mag -22");
    send(99, 30, 0, 0, "R5 mag 30");
    send(99, 20, 0, 1, "R5 mag 19");
    idle();
    repeat (3) @(negedge clk);

    // R7 full stall
    bp_mode = 2;
    @(negedge clk);
    send(40, 13, 0, 0, "R7 stalled coef 13 x40");
    idle(); #1;
    held = out_mag;
    check(out_valid == 1'b1, "R7 valid while stalled", int'(out_valid), 1);
    check(in_ready == 1'b0, "R7 in_ready low while stalled", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    #1;
    check(out_mag == held && out_mag == MAG_W'(520), "R7 held result",
          int'(out_mag), 520);
    check(in_ready == 1'b0, "R7 in_ready still low", int'(in_ready), 0);
    bp_mode = 0;

    // R8 sweep under periodic back-pressure
    @(negedge clk);
    bp_mode = 1;
    for (int i = 0; i < 64; i++) begin
      send((i * 37 + 11) % 256, i % 32, (i * 7 + 3) % 32, i % 2, "R8 sweep order");
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    bp_mode = 0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results drained", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule